// File: doc/BRIEF.md
# Polled Serial Transmit Port

This block is a serial transmitter that a small processor reaches through its peripheral bus at a single byte address. A bus write to that address takes the low byte of the write data and sends it on one output line as an asynchronous serial frame. The frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. A bus read from the same address returns nothing but the transmitter's busy flag. There is no separate status location.

Software sends a string by polling. It reads the address until busy is clear, writes the next character, and repeats. A typical boot sequence sends the characters '1', '3' and a newline this way. The width of each bit time is a number of clock cycles set by the `BIT_CYCLES` parameter.

The request side is a valid/ready channel, but `req_ready` is held high, so every beat is accepted in the cycle it is presented. The block applies no back-pressure. A write that reaches the data address while a frame is in flight is taken off the bus and dropped. Pacing is therefore the job of software, through the busy poll.

Top module: `mmio_serial_tx`

## Requirements
- R1: After reset, `ser_txd` is 1, `tx_busy` is 0, and `rsp_rdata` is zero.
- R2: A beat with `req_valid`=1, `req_write`=1 and `req_addr`=`DEV_ADDR` (default 8'h80), presented while busy is 0, is accepted at that clock edge. `tx_busy` reads 1 from that edge onward.
- R3: An accepted frame drives `ser_txd` in this order: one low start bit, data bits 0 to 7, then one high stop bit. Each bit lasts `BIT_CYCLES` clock cycles and the first bit starts at the accept edge.
- R4: `tx_busy` stays 1 for exactly 10*`BIT_CYCLES` cycles after the accept edge and then returns to 0.
- R5: A read beat (`req_valid`=1, `req_write`=0) at `DEV_ADDR` returns the busy flag in bit 0 of `rsp_rdata` in the same cycle. All other bits read 0.
- R6: A write to `DEV_ADDR` while busy is 1 is ignored. The frame in progress keeps its data and its timing.
- R7: A write to any other address starts nothing. A read of any other address returns zero, and so does a cycle with no read beat.
- R8: Only bits 7:0 of `req_wdata` are sent; the upper bits have no effect on the line.
- R9: Whenever busy is 0, `ser_txd` is 1, including the gap between frames.
- R10: `req_ready` is 1 in every cycle, so every beat completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus beat present |
| req_ready | output | 1 | Beat accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address of the beat |
| req_wdata | input | DATA_W (32) | Write data; low byte is transmitted |
| rsp_rdata | output | DATA_W (32) | Read data, busy in bit 0 |
| ser_txd | output | 1 | Serial output line, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
On every cycle, the assertions check the following:
- the line is high whenever the block is idle;
- busy rises at the accept edge and lasts exactly one frame length, counted independently of the design, so a stray write cannot restart it;
- the start, data and stop slots carry the captured byte;
- read data mirrors busy in bit 0 at the data address and is zero everywhere else.

Only the bench scenarios can show the following:
- whole frames of specific characters arriving bit by bit at mid-bit sample points;
- a write injected mid-frame leaving the frame's bits unchanged;
- the polling loop that sends back-to-back characters;
- the absence of any effect from foreign addresses.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Phase of the transmit sequence.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_e;

  // Bit slots in one frame: start + 8 data + stop.
  localparam int unsigned FRAME_SLOTS = 10;
  localparam int unsigned CHAR_BITS   = 8;

endpackage

// File: rtl/sertx_bus_port.sv
module sertx_bus_port #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h80
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              busy,
  output logic              req_ready,
  output logic              load,
  output logic [7:0]        load_byte,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic hit;
  logic unused_upper;

  // Every beat completes in its own cycle.
  assign req_ready = 1'b1;

  assign hit       = req_valid && (req_addr == DEV_ADDR);
  assign load      = hit && req_write && !busy;
  assign load_byte = req_wdata[7:0];

  assign unused_upper = ^req_wdata[DATA_W-1:8];

  always_comb begin
    rsp_rdata = '0;
    if (hit && !req_write) begin
      rsp_rdata[0] = busy;
    end
  end

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned BIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  output logic       txd,
  output logic       busy
);

  tx_phase_e  phase;
  logic [7:0] shreg;
  logic [2:0] bit_idx;

  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      txd     <= 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          txd <= 1'b1;
          if (load) begin
            phase   <= PH_START;
            shreg   <= load_byte;
            bit_idx <= '0;
            txd     <= 1'b0;
          end
        end
        PH_START: begin
          if (tick) begin
            phase <= PH_DATA;
            txd   <= shreg[0];
            shreg <= {1'b0, shreg[7:1]};
          end
        end
        PH_DATA: begin
          if (tick) begin
            if (bit_idx == 3'(CHAR_BITS - 1)) begin
              phase <= PH_STOP;
              txd   <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              txd     <= shreg[0];
              shreg   <= {1'b0, shreg[7:1]};
            end
          end
        end
        PH_STOP: begin
          if (tick) begin
            phase <= PH_IDLE;
            txd   <= 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          txd   <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/mmio_serial_tx.sv
module mmio_serial_tx #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h80,
  parameter int unsigned BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ser_txd,
  output logic              tx_busy
);

  logic       load;
  logic [7:0] load_byte;
  logic       tick;

  sertx_bus_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_port (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .busy     (tx_busy),
    .req_ready(req_ready),
    .load     (load),
    .load_byte(load_byte),
    .rsp_rdata(rsp_rdata)
  );

  sertx_baud #(
    .BIT_CYCLES(BIT_CYCLES)
  ) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(load),
    .run    (tx_busy),
    .tick   (tick)
  );

  sertx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_byte(load_byte),
    .tick     (tick),
    .txd      (ser_txd),
    .busy     (tx_busy)
  );

endmodule

// File: rtl/mmio_serial_tx_chk.sv
module mmio_serial_tx_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h80,
  parameter int unsigned BIT_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              ser_txd,
  input logic              tx_busy
);

  localparam int unsigned FRAME = 10 * BIT_CYCLES;
  localparam int unsigned CW = $clog2(FRAME + 1);

  logic          accept;
  logic          active;
  logic [CW-1:0] cyc;
  logic [7:0]    cap_byte;
  int unsigned   slot;
  logic [2:0]    data_idx;

  assign accept = req_valid && req_write && (req_addr == DEV_ADDR) && !tx_busy;

  always_comb begin
    slot     = int'(cyc) / BIT_CYCLES;
    data_idx = 3'(slot - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cyc      <= '0;
      cap_byte <= '0;
    end else if (accept) begin
      active   <= 1'b1;
      cyc      <= '0;
      cap_byte <= req_wdata[7:0];
    end else if (active) begin
      if (int'(cyc) == FRAME - 1) begin
        active <= 1'b0;
        cyc    <= '0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  // R2: busy rises at the accept edge and the start bit begins there
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_busy && !ser_txd));

  // R4, R6: busy lasts exactly one frame, untouched by further writes
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy == active);

  // R3: start slot low
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot == 0) |-> !ser_txd);

  // R3, R8: data slots carry the captured low byte, LSB first
  p_data_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot >= 1 && slot <= 8) |-> (ser_txd == cap_byte[data_idx]));

  // R3: stop slot high
  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot == 9) |-> ser_txd);

  // R9: idle line high
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_txd);

  // R5: status read mirrors busy in bit 0 only
  p_rd_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == DEV_ADDR) |->
      (rsp_rdata == DATA_W'(tx_busy)));

  // R7: no read beat at the device address gives zero
  p_rd_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write && req_addr == DEV_ADDR) |-> (rsp_rdata == '0));

endmodule

bind mmio_serial_tx mmio_serial_tx_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .DEV_ADDR  (DEV_ADDR),
  .BIT_CYCLES(BIT_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_rdata(rsp_rdata),
  .ser_txd  (ser_txd),
  .tx_busy  (tx_busy)
);

// File: tb/tb_mmio_serial_tx.sv
module tb_mmio_serial_tx;

  localparam int BITC  = 4;
  localparam int FRAME = 10 * BITC;
  localparam logic [7:0] DEV = 8'h80;

  // {byte, expected frame with bit 0 first on the line}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h31, 10'b1_00110001_0},
    {8'h33, 10'b1_00110011_0},
    {8'h0A, 10'b1_00001010_0},
    {8'h00, 10'b1_00000000_0},
    {8'hFF, 10'b1_11111111_0},
    {8'hA5, 10'b1_10100101_0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        ser_txd;
  logic        tx_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmio_serial_tx #(.BIT_CYCLES(BITC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .ser_txd(ser_txd), .tx_busy(tx_busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  // Write at the next edge and check the whole frame on the line.
  // inject: issue a second write to DEV at sample index 10 (R6).
  task automatic send_frame(input logic [31:0] wd, input logic [9:0] exp_f,
                            input bit inject, input string tag);
    logic [9:0] got;
    bit busy_mid;
    got = '0;
    busy_mid = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = DEV; req_wdata = wd;
    @(negedge clk);
    idle_bus();
    for (int i = 0; i <= FRAME; i++) begin
      if (inject && i == 10) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = DEV; req_wdata = 32'h0000_005A;
      end
      if (inject && i == 11) idle_bus();
      if (i < FRAME && !tx_busy) busy_mid = 1'b0;
      if ((i % BITC) == BITC / 2) got[i / BITC] = ser_txd;
      if (i == FRAME) begin
        chk(!tx_busy, {"R4 busy clear after frame ", tag}, 32'(tx_busy), 32'd0);
        chk(ser_txd, {"R9 line high after frame ", tag}, 32'(ser_txd), 32'd1);
      end else begin
        @(negedge clk);
      end
    end
    chk(busy_mid, {"R2/R4 busy held through frame ", tag}, 32'(busy_mid), 32'd1);
    chk(got == exp_f, {"R3 frame bits ", tag}, 32'(got), 32'(exp_f));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_bus();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser_txd && !tx_busy && rsp_rdata == 0, "R1 reset state",
        {30'd0, ser_txd, tx_busy}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_txd && !tx_busy, "R1 after release", {30'd0, ser_txd, tx_busy}, 32'h2);
    chk(req_ready, "R10 ready high", 32'(req_ready), 32'd1);

    // Vector table; upper write bits are junk (R8)
    for (int v = 0; v < NVEC; v++) begin
      send_frame({24'hDEADBE, VEC[v][17:10]}, VEC[v][9:0], 1'b0, $sformatf("vec%0d", v));
      repeat (2) @(negedge clk);
    end

    // R5: read status while busy and idle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = DEV; req_wdata = 32'h41;
    @(negedge clk);
    req_write = 1'b0; req_wdata = '0;
    #1;
    chk(rsp_rdata == 32'h1, "R5 read busy=1", rsp_rdata, 32'h1);
    chk(req_ready, "R10 ready on read", 32'(req_ready), 32'd1);
    req_addr = 8'h84;
    #1;
    chk(rsp_rdata == 32'h0, "R7 other addr read zero", rsp_rdata, 32'h0);
    idle_bus();
    #1;
    chk(rsp_rdata == 32'h0, "R7 no beat reads zero", rsp_rdata, 32'h0);
    while (tx_busy) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = DEV;
    #1;
    chk(rsp_rdata == 32'h0, "R5 read busy=0", rsp_rdata, 32'h0);
    idle_bus();

    // R6: write during a frame is ignored
    send_frame(32'h0000_00C3, 10'b1_11000011_0, 1'b1, "R6 inject");

    // R7: write to other address starts nothing
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h81; req_wdata = 32'h00;
    @(negedge clk);
    idle_bus();
    repeat (BITC) @(negedge clk);
    chk(!tx_busy && ser_txd, "R7 foreign write no effect",
        {30'd0, ser_txd, tx_busy}, 32'h2);

    // Polled string '1','3','\n' back to back
    for (int c = 0; c < 3; c++) begin
      req_valid = 1'b1; req_write = 1'b0; req_addr = DEV;
      #1;
      while (rsp_rdata[0]) begin @(negedge clk); #1; end
      idle_bus();
      send_frame({24'h0, VEC[c][17:10]}, VEC[c][9:0], 1'b0, $sformatf("poll%0d", c));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule